// File: doc/BRIEF.md
# Time-Slot Bit Insertion Port

The block sits on a transmit serial path that carries one bit per clock, framed as T1 or E1. It keeps its own count of the outgoing bit position: the bit inside the slot, the slot inside the frame, and whether the frame is odd or even. At the bit positions chosen by its configuration, it replaces the outgoing bit with a bit taken from an external data pin. All other bits pass through unchanged.

The configuration gives a target slot number, an 8-bit mask that picks bits inside that slot, a frame qualifier (all, odd or even frames), a flag that also targets the T1 framing bit, and an enable. A strobe output, `dl_clk_o`, goes high only during the bit periods that are overwritten. The external source uses each rising edge of this strobe to present its next NRZ bit on `dl_data_i`, and that bit is placed on `ser_o` in the same bit period.

Top module: `ts_bit_insert`

## Requirements
- R1: After reset is released, the first bit period is position 0 of frame index 0, and frame index 0 counts as even.
- R2: With `e1_mode_i`=0 (T1), a frame is 193 bit periods. Position 0 is the framing bit. It is followed by slots numbered 1 to 24, each 8 bits long. A `slot_sel_i` of 0 or above 24 never matches in T1 mode.
- R3: With `e1_mode_i`=1 (E1), a frame is 256 bit periods, made of slots numbered 0 to 31, each 8 bits long.
- R4: Inside a slot, the bit sent first is selected by `bit_mask_i[7]` and the bit sent last by `bit_mask_i[0]`. Any combination of the eight mask bits is accepted.
- R5: `dl_clk_o` is high during a bit period exactly when that period is selected for insertion, and low in every other period.
- R6: In a selected period, `ser_o` equals `dl_data_i` in that same period. In every other period, `ser_o` equals `ser_i`.
- R7: While `en_i` is 0, `dl_clk_o` stays low and `ser_o` equals `ser_i`, whatever the other settings are.
- R8: `frame_qual_i` encodes the frames used for insertion: 2'b01 means odd frames only, 2'b10 means even frames only, and 2'b00 or 2'b11 means all frames. The frame index goes up by one at each frame wrap.
- R9: With `fbit_sel_i`=1 in T1 mode, the framing bit is selected, subject to the enable and the frame qualifier. In E1 mode `fbit_sel_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| e1_mode_i | input | 1 | 0 selects T1 framing, 1 selects E1 framing |
| en_i | input | 1 | Insertion enable |
| slot_sel_i | input | 5 | Target slot number |
| bit_mask_i | input | 8 | Bit-select mask; bit 7 is the first bit sent |
| frame_qual_i | input | 2 | Frame qualifier: all, odd or even |
| fbit_sel_i | input | 1 | Also target the T1 framing bit |
| ser_i | input | 1 | Incoming serial transmit bit |
| dl_data_i | input | 1 | External NRZ insertion data |
| ser_o | output | 1 | Outgoing serial bit after insertion |
| dl_clk_o | output | 1 | Strobe, high only on selected bit periods |

## Verification
Several configurations are run back to back, with pseudo-random data on both serial inputs, and every cycle is compared against a position model. The disabled case with a full mask shows that the enable really blocks insertion. The sparse masks 8'hC3, 8'h81 and 8'h3C, each in a different slot, test the bit ordering inside a slot and the slot decode at both ends of the T1 range. The odd and even qualifiers, one of them combined with framing-bit selection, test the frame parity from reset onward and the placement of the framing bit. Slots 0 and 25 in T1 mode show that out-of-range slot numbers match nothing. The switch into E1 mode, with slots 0 and 31 and the framing-bit flag still set, tests the 256-bit frame length and that the flag is ignored in E1.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SLOT_W        = 8;
  localparam int T1_SLOTS      = 24;
  localparam int E1_SLOTS      = 32;
  localparam int T1_FRAME_BITS = 1 + T1_SLOTS * SLOT_W;
  localparam int E1_FRAME_BITS = E1_SLOTS * SLOT_W;
  localparam int POS_W         = $clog2(E1_FRAME_BITS);
  localparam int SLOT_IDX_W    = $clog2(E1_SLOTS);
  localparam int BIT_IDX_W     = $clog2(SLOT_W);

  typedef enum logic [1:0] {
    QUAL_ALL  = 2'b00,
    QUAL_ODD  = 2'b01,
    QUAL_EVEN = 2'b10,
    QUAL_ANY  = 2'b11
  } frame_qual_e;
endpackage

// File: rtl/tsi_pos_counter.sv
module tsi_pos_counter
  import tsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             e1_mode_i,
  output logic [POS_W-1:0] pos_o,
  output logic             frame_odd_o,
  output logic             frame_wrap_o
);
  localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_FRAME_BITS - 1);
  localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_FRAME_BITS - 1);

  logic [POS_W-1:0] last;

  assign last = e1_mode_i ? E1_LAST : T1_LAST;
  // >= also wraps a position left beyond a shorter frame after a mode change
  assign frame_wrap_o = (pos_o >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o       <= '0;
      frame_odd_o <= 1'b0;
    end else if (frame_wrap_o) begin
      pos_o       <= '0;
      frame_odd_o <= ~frame_odd_o;
    end else begin
      pos_o <= pos_o + 1'b1;
    end
  end

  p_parity_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_wrap_o |=> (frame_odd_o != $past(frame_odd_o)));

  p_wrap_to_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_wrap_o |=> (pos_o == '0));

  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_wrap_o |=> (pos_o == $past(pos_o) + 1'b1));
endmodule

// File: rtl/tsi_slot_decode.sv
module tsi_slot_decode
  import tsi_pkg::*;
(
  input  logic                  e1_mode_i,
  input  logic [POS_W-1:0]      pos_i,
  output logic                  is_fbit_o,
  output logic [SLOT_IDX_W-1:0] slot_o,
  output logic [BIT_IDX_W-1:0]  bit_o
);
  logic [POS_W-1:0] rel;

  always_comb begin
    is_fbit_o = 1'b0;
    rel       = pos_i;
    if (!e1_mode_i) begin
      is_fbit_o = (pos_i == '0);
      rel       = pos_i - 1'b1;
    end
    bit_o  = rel[BIT_IDX_W-1:0];
    // T1 slots are numbered from 1, E1 slots from 0
    slot_o = rel[POS_W-1:BIT_IDX_W] + SLOT_IDX_W'(!e1_mode_i);
    if (is_fbit_o) begin
      slot_o = '0;
      bit_o  = '0;
    end
  end
endmodule

// File: rtl/tsi_select.sv
module tsi_select
  import tsi_pkg::*;
(
  input  logic                  en_i,
  input  logic                  e1_mode_i,
  input  logic                  is_fbit_i,
  input  logic [SLOT_IDX_W-1:0] slot_i,
  input  logic [BIT_IDX_W-1:0]  bit_i,
  input  logic [SLOT_IDX_W-1:0] slot_sel_i,
  input  logic [SLOT_W-1:0]     bit_mask_i,
  input  frame_qual_e           frame_qual_i,
  input  logic                  fbit_sel_i,
  input  logic                  frame_odd_i,
  output logic                  hit_o
);
  logic frame_ok;
  logic slot_hit;
  logic fbit_hit;

  always_comb begin
    unique case (frame_qual_i)
      QUAL_ODD:  frame_ok = frame_odd_i;
      QUAL_EVEN: frame_ok = !frame_odd_i;
      default:   frame_ok = 1'b1;
    endcase
  end

  // the mask is MSB first: bit_mask_i[SLOT_W-1] picks the first bit sent
  assign slot_hit = !is_fbit_i && (slot_i == slot_sel_i)
                    && bit_mask_i[BIT_IDX_W'(SLOT_W - 1) - bit_i];
  assign fbit_hit = is_fbit_i && fbit_sel_i && !e1_mode_i;
  assign hit_o    = en_i && frame_ok && (slot_hit || fbit_hit);
endmodule

// File: rtl/ts_bit_insert.sv
module ts_bit_insert
  import tsi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       e1_mode_i,
  input  logic       en_i,
  input  logic [4:0] slot_sel_i,
  input  logic [7:0] bit_mask_i,
  input  logic [1:0] frame_qual_i,
  input  logic       fbit_sel_i,
  input  logic       ser_i,
  input  logic       dl_data_i,
  output logic       ser_o,
  output logic       dl_clk_o
);
  logic [POS_W-1:0]      pos;
  logic                  frame_odd;
  logic                  frame_wrap;
  logic                  is_fbit;
  logic [SLOT_IDX_W-1:0] slot;
  logic [BIT_IDX_W-1:0]  bit_idx;
  logic                  hit;

  tsi_pos_counter u_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .e1_mode_i   (e1_mode_i),
    .pos_o       (pos),
    .frame_odd_o (frame_odd),
    .frame_wrap_o(frame_wrap)
  );

  tsi_slot_decode u_dec (
    .e1_mode_i(e1_mode_i),
    .pos_i    (pos),
    .is_fbit_o(is_fbit),
    .slot_o   (slot),
    .bit_o    (bit_idx)
  );

  tsi_select u_sel (
    .en_i        (en_i),
    .e1_mode_i   (e1_mode_i),
    .is_fbit_i   (is_fbit),
    .slot_i      (slot),
    .bit_i       (bit_idx),
    .slot_sel_i  (slot_sel_i),
    .bit_mask_i  (bit_mask_i),
    .frame_qual_i(frame_qual_e'(frame_qual_i)),
    .fbit_sel_i  (fbit_sel_i),
    .frame_odd_i (frame_odd),
    .hit_o       (hit)
  );

  assign dl_clk_o = hit;
  assign ser_o    = hit ? dl_data_i : ser_i;

  p_disabled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!dl_clk_o && (ser_o == ser_i)));

  p_pass_through_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dl_clk_o |-> (ser_o == ser_i));

  p_insert_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_clk_o |-> (ser_o == dl_data_i));

  p_no_fbit_in_e1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e1_mode_i |-> !is_fbit);

  p_t1_slot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e1_mode_i && !is_fbit) |-> (slot >= 1 && slot <= SLOT_IDX_W'(T1_SLOTS)));
endmodule

// File: tb/ts_bit_insert_bench.sv
module ts_bit_insert_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       e1_mode = 1'b0;
  logic       en = 1'b0;
  logic [4:0] slot_sel = '0;
  logic [7:0] bit_mask = '0;
  logic [1:0] frame_qual = '0;
  logic       fbit_sel = 1'b0;
  logic       ser_in = 1'b0;
  logic       dl_data = 1'b0;
  logic       ser_out;
  logic       dl_clk;

  int checks = 0;
  int failures = 0;
  int hits = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // behavioural model state
  int m_pos = 0;
  int m_frame = 0;

  ts_bit_insert u_ts_bit_insert (
    .clk_i(clk), .rst_ni(rst_n), .e1_mode_i(e1_mode), .en_i(en),
    .slot_sel_i(slot_sel), .bit_mask_i(bit_mask), .frame_qual_i(frame_qual),
    .fbit_sel_i(fbit_sel), .ser_i(ser_in), .dl_data_i(dl_data),
    .ser_o(ser_out), .dl_clk_o(dl_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0;
      m_frame = 0;
    end else begin
      int flen;
      flen = e1_mode ? 256 : 193;
      if (m_pos >= flen - 1) begin
        m_pos = 0;
        m_frame++;
      end else m_pos++;
    end
  end

  function automatic bit model_hit();
    bit frame_ok;
    int slot, b;
    if (!en) return 0;
    case (frame_qual)
      2'b01:   frame_ok = (m_frame % 2) == 1;
      2'b10:   frame_ok = (m_frame % 2) == 0;
      default: frame_ok = 1;
    endcase
    if (!frame_ok) return 0;
    if (!e1_mode) begin
      if (m_pos == 0) return fbit_sel;
      slot = (m_pos - 1) / 8 + 1;
      b = (m_pos - 1) % 8;
    end else begin
      slot = m_pos / 8;
      b = m_pos % 8;
    end
    return (slot == int'(slot_sel)) && bit_mask[7 - b];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_clk, exp_ser;
      exp_clk = model_hit();
      exp_ser = exp_clk ? dl_data : ser_in;
      if (exp_clk) hits++;
      checks++;
      if (dl_clk !== exp_clk) begin
        failures++;
        $display("FAIL %s dl_clk pos=%0d frame=%0d act=%b exp=%b", tag, m_pos, m_frame, dl_clk, exp_clk);
      end
      checks++;
      if (ser_out !== exp_ser) begin
        failures++;
        $display("FAIL %s ser_o pos=%0d frame=%0d act=%b exp=%b", tag, m_pos, m_frame, ser_out, exp_ser);
      end
    end
  end

  // fresh serial data each bit period, driven away from the edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_in = lfsr[0];
    dl_data = lfsr[5];
  end

  task automatic phase(input string t, input bit e1, input bit e, input int s,
                       input logic [7:0] m, input logic [1:0] q, input bit f, input int n);
    int h0;
    @(posedge clk); #2;
    tag = t; e1_mode = e1; en = e; slot_sel = 5'(s); bit_mask = m;
    frame_qual = q; fbit_sel = f;
    h0 = hits;
    repeat (n) @(posedge clk);
    $display("phase %s hits=%0d", t, hits - h0);
  endtask

  task automatic expect_hits(input string t, input int got, input bit want_some);
    checks++;
    if ((got > 0) != want_some) begin
      failures++;
      $display("FAIL %s hit_presence act=%0d exp_nonzero=%b", t, got, want_some);
    end
  endtask

  initial begin
    int h;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: first period after reset is the framing bit of even frame 0
    tag = "R1"; en = 1'b1; fbit_sel = 1'b1; frame_qual = 2'b10;
    @(negedge clk);
    checks++;
    if (dl_clk !== 1'b1) begin
      failures++;
      $display("FAIL R1 dl_clk at first period act=%b exp=1", dl_clk);
    end
    phase("R7", 1'b0, 1'b0, 9, 8'hFF, 2'b00, 1'b1, 500);
    h = hits; phase("R4_R5_R6", 1'b0, 1'b1, 9, 8'hC3, 2'b00, 1'b0, 800); expect_hits("R5", hits - h, 1);
    h = hits; phase("R8_odd", 1'b0, 1'b1, 24, 8'h81, 2'b01, 1'b0, 800); expect_hits("R8", hits - h, 1);
    h = hits; phase("R9_R2", 1'b0, 1'b1, 1, 8'h3C, 2'b10, 1'b1, 800); expect_hits("R9", hits - h, 1);
    h = hits; phase("R2_slot0", 1'b0, 1'b1, 0, 8'hFF, 2'b11, 1'b0, 400); expect_hits("R2", hits - h, 0);
    h = hits; phase("R2_slot25", 1'b0, 1'b1, 25, 8'hFF, 2'b00, 1'b0, 400); expect_hits("R2", hits - h, 0);
    h = hits; phase("R3_R9", 1'b1, 1'b1, 0, 8'hFF, 2'b00, 1'b1, 1100); expect_hits("R3", hits - h, 1);
    h = hits; phase("R3_R8", 1'b1, 1'b1, 31, 8'h55, 2'b10, 1'b0, 1100); expect_hits("R8", hits - h, 1);
    h = hits; phase("R7_e1", 1'b1, 1'b0, 5, 8'hFF, 2'b00, 1'b0, 600); expect_hits("R7", hits - h, 0);
    h = hits; phase("R4_t1", 1'b0, 1'b1, 12, 8'h01, 2'b00, 1'b0, 600); expect_hits("R4", hits - h, 1);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule